// File: doc/BRIEF.md
# Dual-Mode External Memory Bus Controller

This block connects a CPU's internal request port to an external memory bus with 8 data bits and 20 address bits. A static mode input selects between two pin arrangements. In split mode the whole address has its own pins. In shared mode the low address byte goes out on the data pins first and is marked by an address-latch pulse. Only the upper twelve address bits keep their own pins. Instruction fetches use a program-fetch strobe. Data reads and data writes each have their own strobe. A wait input can stretch data accesses.

The block runs on a clock whose period is one half of a CPU cycle. With no wait states, each strobe is low for two clock cycles, which is one CPU cycle. The CPU side uses a valid/ready handshake. The controller accepts a request only when it is idle. It returns read data together with a one-cycle ready pulse. A forced-external input controls where instruction fetches go. When it is high, fetches below a parameterised internal-ROM limit do not touch the bus. They complete at once with a "served internally" flag. When it is low, every fetch goes out on the bus.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is high and after it is released with no request pending, all three strobes are high, the latch pulse is low, the data pins are not driven and ready is low.
- R2: In split mode (mode input = 1) the full address is on the high and low address pins and the latch pulse never rises. The strobe falls on the second rising edge after the accepting edge, and ready is high after the fourth edge, counting the accepting edge as the first.
- R3: In shared mode (mode input = 0) the latch pulse is high for two cycles while the data pins drive the low address byte. Then follows one cycle with the latch pulse low, the low byte still driven and every strobe high. Only after that does the strobe fall, and the low address pins read 0. Ready comes two cycles later than in split mode.
- R4: Kind code 00 uses the program-fetch strobe. Code 01 uses the read strobe, 10 uses the write strobe, and 11 is handled as a read. At most one strobe is low at a time, and without wait states it stays low for exactly two cycles.
- R5: For fetches and reads, the data input sampled on the edge that ends the strobe is returned on the read-data output while ready is high.
- R6: For writes, the data pins are driven with the write byte from the cycle the write strobe falls until one cycle after it rises.
- R7: For reads and writes, each cycle in which the wait input is high at the edge that would end the strobe keeps the strobe low for one more cycle.
- R8: For fetches, the wait input has no effect: the strobe is low for exactly two cycles.
- R9: When the forced-external input is high, a fetch below the internal-ROM limit (default 0x20000) produces no strobe and no latch pulse. It returns ready on the cycle after the accepting edge, with the internal flag at 1 and read data 0.
- R10: When the forced-external input is low, every fetch goes to the bus whatever its address. Fetches at or above the limit, and all data accesses, always go to the bus.
- R11: The mode and forced-external inputs are sampled on the accepting edge. Changing them during an access does not change how that access runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one half CPU cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| mode_sep | input | 1 | 1 = split address/data pins, 0 = shared pins |
| ext_fetch_n | input | 1 | Low forces all fetches to the bus |
| cpu_valid | input | 1 | Request valid |
| cpu_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| cpu_addr | input | 20 | Request address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with ready |
| cpu_int | output | 1 | Fetch served internally, valid with ready |
| bus_addr_hi | output | 12 | Address bits 19..8 |
| bus_addr_lo | output | 8 | Address bits 7..0 in split mode, 0 in shared mode |
| bus_dout | output | 8 | Data pin output value |
| bus_doe | output | 1 | Data pin output enable |
| bus_din | input | 8 | Data pin input value |
| bus_ale | output | 1 | Address-latch pulse, high active |
| bus_pse_n | output | 1 | Program-fetch strobe, low active |
| bus_rd_n | output | 1 | Data read strobe, low active |
| bus_wr_n | output | 1 | Data write strobe, low active |
| bus_wait | input | 1 | Stretch request for data accesses |

## Verification
The edge that would end a strobe is also where the wait input is judged. So completion of the access and the stretch decision fall in the same cycle. The bench raises wait at the negative edge just before that ending edge, for a chosen number of cycles. It does this for reads, writes and fetches. It then checks two things: the number of low strobe cycles it counts on the pins, and the latency to ready. For data accesses each wait cycle must add exactly one cycle, and a fetch must not stretch at all. A second coincidence is the mode and forced-external pins changing in the cycle just after a request is accepted. The bench toggles both there and expects the access to finish in the mode it started in.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALE_A = 3'd1,
    ST_ALE_B = 3'd2,
    ST_SETUP = 3'd3,
    ST_STB_A = 3'd4,
    ST_STB_B = 3'd5,
    ST_TAIL  = 3'd6
  } xb_state_e;

  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_RDALT = 2'b11
  } xb_kind_e;

  localparam int NUM_STB = 3;
  localparam int STB_PSE = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;

  // Which strobe line a request kind uses.
  function automatic int kind_strobe(xb_kind_e k);
    case (k)
      K_FETCH: return STB_PSE;
      K_WRITE: return STB_WR;
      default: return STB_RD;
    endcase
  endfunction

  function automatic logic kind_is_data(xb_kind_e k);
    return k != K_FETCH;
  endfunction

endpackage

// File: rtl/xbus_req.sv
module xbus_req
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int INT_ROM_BYTES = 32'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [1:0]        cpu_kind,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              mode_sep,
  input  logic              ext_fetch_n,
  output logic              in_local,
  output logic              in_sep,
  output xb_kind_e          nx_kind,
  output logic [ADDR_W-1:0] nx_addr,
  output logic [DATA_W-1:0] nx_wdata,
  output logic              nx_sep,
  output logic              nx_local,
  output xb_kind_e          q_kind,
  output logic              q_local
);

  localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(INT_ROM_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sep_q;
  xb_kind_e          in_kind;

  assign in_kind  = xb_kind_e'(cpu_kind);
  assign in_sep   = mode_sep;
  assign in_local = (in_kind == K_FETCH) && ext_fetch_n &&
                    ({1'b0, cpu_addr} < ROM_LIM);

  always_comb begin
    if (accept) begin
      nx_kind  = in_kind;
      nx_addr  = cpu_addr;
      nx_wdata = cpu_wdata;
      nx_sep   = in_sep;
      nx_local = in_local;
    end else begin
      nx_kind  = q_kind;
      nx_addr  = addr_q;
      nx_wdata = wdata_q;
      nx_sep   = sep_q;
      nx_local = q_local;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_kind  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
      sep_q   <= 1'b1;
      q_local <= 1'b0;
    end else begin
      q_kind  <= nx_kind;
      addr_q  <= nx_addr;
      wdata_q <= nx_wdata;
      sep_q   <= nx_sep;
      q_local <= nx_local;
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cpu_valid,
  input  logic      in_local,
  input  logic      in_sep,
  input  xb_kind_e  q_kind,
  input  logic      bus_wait,
  output logic      accept,
  output xb_state_e state_q,
  output xb_state_e state_nx
);

  logic stretch;
  assign stretch = bus_wait && kind_is_data(q_kind);

  always_comb begin
    state_nx = state_q;
    accept   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          accept = 1'b1;
          if (in_local)    state_nx = ST_TAIL;
          else if (in_sep) state_nx = ST_SETUP;
          else             state_nx = ST_ALE_A;
        end
      end
      ST_ALE_A: state_nx = ST_ALE_B;
      ST_ALE_B: state_nx = ST_SETUP;
      ST_SETUP: state_nx = ST_STB_A;
      ST_STB_A: state_nx = ST_STB_B;
      ST_STB_B: state_nx = stretch ? ST_STB_B : ST_TAIL;
      ST_TAIL:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nx;
  end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  xb_state_e                state_nx,
  input  xb_kind_e                 nx_kind,
  input  logic [ADDR_W-1:0]        nx_addr,
  input  logic [DATA_W-1:0]        nx_wdata,
  input  logic                     nx_sep,
  input  logic                     nx_local,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_addr_lo,
  output logic [DATA_W-1:0]        bus_dout,
  output logic                     bus_doe,
  output logic                     bus_ale,
  output logic                     bus_pse_n,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n
);

  localparam int LO_W = DATA_W;
  localparam int HI_W = ADDR_W - DATA_W;

  logic               ext_act, in_ale, in_stb, mux_addr, wr_win;
  logic [NUM_STB-1:0] stb_n_q;
  int                 stb_sel;

  always_comb begin
    ext_act  = (state_nx != ST_IDLE) && !nx_local;
    in_ale   = (state_nx == ST_ALE_A) || (state_nx == ST_ALE_B);
    in_stb   = (state_nx == ST_STB_A) || (state_nx == ST_STB_B);
    mux_addr = !nx_sep && (in_ale || state_nx == ST_SETUP);
    wr_win   = (nx_kind == K_WRITE) && !nx_local &&
               (in_stb || state_nx == ST_TAIL);
    stb_sel  = kind_strobe(nx_kind);
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) stb_n_q[g] <= 1'b1;
      else     stb_n_q[g] <= !(in_stb && stb_sel == g);
    end
  end

  assign bus_pse_n = stb_n_q[STB_PSE];
  assign bus_rd_n  = stb_n_q[STB_RD];
  assign bus_wr_n  = stb_n_q[STB_WR];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr_hi <= '0;
      bus_addr_lo <= '0;
      bus_dout    <= '0;
      bus_doe     <= 1'b0;
      bus_ale     <= 1'b0;
    end else begin
      if (ext_act) begin
        bus_addr_hi <= nx_addr[ADDR_W-1 -: HI_W];
        bus_addr_lo <= nx_sep ? nx_addr[LO_W-1:0] : '0;
      end
      bus_ale <= in_ale;
      bus_doe <= mux_addr || wr_win;
      if (mux_addr)    bus_dout <= nx_addr[LO_W-1:0];
      else if (wr_win) bus_dout <= nx_wdata;
      else             bus_dout <= '0;
    end
  end

endmodule

// File: rtl/xbus_resp.sv
module xbus_resp
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xb_state_e         state_q,
  input  xb_state_e         state_nx,
  input  xb_kind_e          q_kind,
  input  logic              nx_local,
  input  logic [DATA_W-1:0] bus_din,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_int
);

  logic finish_ext, finish_loc;

  assign finish_ext = (state_q == ST_STB_B) && (state_nx == ST_TAIL);
  assign finish_loc = (state_q == ST_IDLE)  && (state_nx == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      cpu_int   <= 1'b0;
    end else begin
      cpu_ready <= state_nx == ST_TAIL;
      cpu_int   <= finish_loc && nx_local;
      if (finish_ext)
        cpu_rdata <= (q_kind == K_WRITE) ? '0 : bus_din;
      else if (finish_loc)
        cpu_rdata <= '0;
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int INT_ROM_BYTES = 32'h20000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_sep,
  input  logic                     ext_fetch_n,
  input  logic                     cpu_valid,
  input  logic [1:0]               cpu_kind,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic                     cpu_ready,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     cpu_int,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_addr_lo,
  output logic [DATA_W-1:0]        bus_dout,
  output logic                     bus_doe,
  input  logic [DATA_W-1:0]        bus_din,
  output logic                     bus_ale,
  output logic                     bus_pse_n,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  input  logic                     bus_wait
);

  logic              accept, in_local, in_sep, nx_sep, nx_local, q_local;
  xb_kind_e          nx_kind, q_kind;
  logic [ADDR_W-1:0] nx_addr;
  logic [DATA_W-1:0] nx_wdata;
  xb_state_e         state_q, state_nx;

  xbus_req #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_ROM_BYTES(INT_ROM_BYTES)
  ) u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mode_sep(mode_sep), .ext_fetch_n(ext_fetch_n),
    .in_local(in_local), .in_sep(in_sep),
    .nx_kind(nx_kind), .nx_addr(nx_addr), .nx_wdata(nx_wdata),
    .nx_sep(nx_sep), .nx_local(nx_local),
    .q_kind(q_kind), .q_local(q_local)
  );

  xbus_seq u_seq (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid),
    .in_local(in_local), .in_sep(in_sep), .q_kind(q_kind),
    .bus_wait(bus_wait), .accept(accept),
    .state_q(state_q), .state_nx(state_nx)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .state_nx(state_nx),
    .nx_kind(nx_kind), .nx_addr(nx_addr), .nx_wdata(nx_wdata),
    .nx_sep(nx_sep), .nx_local(nx_local),
    .bus_addr_hi(bus_addr_hi), .bus_addr_lo(bus_addr_lo),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_ale(bus_ale),
    .bus_pse_n(bus_pse_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  xbus_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .state_q(state_q), .state_nx(state_nx),
    .q_kind(q_kind), .nx_local(nx_local), .bus_din(bus_din),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_int(cpu_int)
  );

  logic unused_q_local;
  assign unused_q_local = q_local;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cpu_ready,
  input logic cpu_int,
  input logic bus_doe,
  input logic bus_ale,
  input logic bus_pse_n,
  input logic bus_rd_n,
  input logic bus_wr_n
);

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({!bus_pse_n, !bus_rd_n, !bus_wr_n}) <= 1);

  // R3
  ale_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_pse_n && bus_rd_n && bus_wr_n));

  // R6
  wr_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_doe);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> bus_doe);

  // R5
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R8
  fetch_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_pse_n && $past(!bus_pse_n)) |-> $past(bus_pse_n, 2));

  // R9
  local_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_int |-> (cpu_ready && bus_pse_n && !bus_ale));

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_int(cpu_int),
  .bus_doe(bus_doe), .bus_ale(bus_ale), .bus_pse_n(bus_pse_n),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_sep = 1'b1, ext_fetch_n = 1'b1;
  logic          cpu_valid = 1'b0;
  logic [1:0]    cpu_kind = 2'b00;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_int, bus_doe, bus_ale;
  logic          bus_pse_n, bus_rd_n, bus_wr_n;
  logic [DW-1:0] cpu_rdata, bus_addr_lo, bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic [11:0]   bus_addr_hi;
  logic          bus_wait = 1'b0;

  int checks = 0, errors = 0;
  int wait_req = 0;

  xbus_ctrl uut (
    .clk(clk), .rst(rst), .mode_sep(mode_sep), .ext_fetch_n(ext_fetch_n),
    .cpu_valid(cpu_valid), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .cpu_int(cpu_int), .bus_addr_hi(bus_addr_hi), .bus_addr_lo(bus_addr_lo),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_ale(bus_ale), .bus_pse_n(bus_pse_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_wait(bus_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memf(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h9};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    bit            loc;
    int            stb;
    int            ale;
    string         tag;
  } exp_t;

  exp_t sb[$];

  // Bus model and monitor
  int pse_cnt = 0, rd_cnt = 0, wr_cnt = 0, ale_cnt = 0, run = 0, wait_used = 0;
  int gap_err = 0, doe_err = 0, lo_err = 0;
  logic [DW-1:0] lat_lo = '0, cap_wd = '0;
  logic [AW-1:0] cap_addr = '0;
  logic          prev_ale = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      logic low;
      low = !bus_pse_n || !bus_rd_n || !bus_wr_n;
      if (bus_ale) begin
        ale_cnt++;
        lat_lo = bus_dout;
        if (!bus_doe) doe_err++;
      end
      if (prev_ale && !bus_ale && (low || !bus_doe || bus_dout != lat_lo)) gap_err++;
      prev_ale = bus_ale;
      if (!bus_pse_n) pse_cnt++;
      if (!bus_rd_n)  rd_cnt++;
      if (!bus_wr_n) begin
        wr_cnt++;
        cap_wd = bus_dout;
        if (!bus_doe) doe_err++;
      end
      if (low) begin
        cap_addr = {bus_addr_hi, (ale_cnt > 0) ? lat_lo : bus_addr_lo};
        if (ale_cnt > 0 && bus_addr_lo != 0) lo_err++;
        bus_din = memf(cap_addr);
        run++;
        if (run >= 2 && wait_used < wait_req) begin
          bus_wait = 1'b1;
          wait_used++;
        end else bus_wait = 1'b0;
      end else begin
        run = 0;
        bus_wait = 1'b0;
      end
      if (cpu_ready) begin
        if (sb.size() == 0) begin
          check(0, "R5", "unexpected ready", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cpu_int == e.loc, e.tag, "internal flag", cpu_int, e.loc);
          if (e.kind != 2'b10)
            check(cpu_rdata == e.rdata, e.tag, "read data", cpu_rdata, e.rdata);
          check(pse_cnt == ((e.kind == 2'b00 && !e.loc) ? e.stb : 0), e.tag, "fetch strobe cycles", pse_cnt, e.stb);
          check(rd_cnt == (e.kind[0] ? e.stb : 0), e.tag, "read strobe cycles", rd_cnt, e.stb);
          check(wr_cnt == (e.kind == 2'b10 ? e.stb : 0), e.tag, "write strobe cycles", wr_cnt, e.stb);
          check(ale_cnt == e.ale, e.tag, "latch pulse cycles", ale_cnt, e.ale);
          check(gap_err == 0 && lo_err == 0, "R3", "shared-mode gap/low pins", gap_err + lo_err, 0);
          if (!e.loc)
            check(cap_addr == e.addr, e.tag, "bus address", cap_addr, e.addr);
          if (e.kind == 2'b10) begin
            check(cap_wd == e.wdata, "R6", "write byte", cap_wd, e.wdata);
            check(bus_doe && bus_wr_n && bus_dout == e.wdata, "R6", "write hold after strobe", bus_dout, e.wdata);
          end
          check(doe_err == 0, "R6", "data pins driven", doe_err, 0);
        end
        pse_cnt = 0; rd_cnt = 0; wr_cnt = 0; ale_cnt = 0; wait_used = 0;
        gap_err = 0; doe_err = 0; lo_err = 0;
      end
    end
  end

  // Driver: pushes expected result, then runs the handshake
  task automatic access(logic [1:0] kind, logic [AW-1:0] addr, logic [DW-1:0] wd,
                        logic sep, logic extn, int waits, bit flip, string tag);
    exp_t e;
    int   n, lat;
    bit   data;
    @(negedge clk);
    data    = (kind != 2'b00);
    e.kind  = kind;
    e.addr  = addr;
    e.wdata = wd;
    e.loc   = (kind == 2'b00) && extn && (addr < 20'h20000);
    e.rdata = (e.loc || kind == 2'b10) ? 8'h00 : memf(addr);
    e.stb   = e.loc ? 0 : 2 + (data ? waits : 0);
    e.ale   = (!e.loc && !sep) ? 2 : 0;
    e.tag   = tag;
    lat     = e.loc ? 1 : ((sep ? 4 : 6) + (data ? waits : 0));
    sb.push_back(e);
    mode_sep = sep; ext_fetch_n = extn; wait_req = waits;
    cpu_kind = kind; cpu_addr = addr; cpu_wdata = wd; cpu_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        cpu_valid = 1'b0;
        if (flip) begin
          mode_sep = !sep;
          ext_fetch_n = !extn;
        end
      end
    end while (!cpu_ready && n < 200);
    check(n == lat, tag, "cycles to ready", n, lat);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R11 watchdog expired actual=%0d expected=0", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cpu_valid = 1'b1;
    repeat (4) @(negedge clk);
    // R1: state during reset
    check(bus_pse_n && bus_rd_n && bus_wr_n && !bus_ale && !bus_doe && !cpu_ready,
          "R1", "idle pins in reset", {bus_pse_n, bus_rd_n, bus_wr_n, bus_ale, bus_doe, cpu_ready}, 6'b111000);
    cpu_valid = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_pse_n && bus_rd_n && bus_wr_n && !bus_ale && !bus_doe && !cpu_ready,
          "R1", "idle pins after reset", {bus_pse_n, bus_rd_n, bus_wr_n, bus_ale, bus_doe, cpu_ready}, 6'b111000);

    access(2'b01, 20'h12345, 8'h00, 1'b1, 1'b1, 0, 1'b0, "R2");
    access(2'b00, 20'h00100, 8'h00, 1'b1, 1'b0, 0, 1'b0, "R10");
    access(2'b00, 20'h00100, 8'h00, 1'b1, 1'b1, 0, 1'b0, "R9");
    access(2'b00, 20'h3A5C0, 8'h00, 1'b1, 1'b1, 0, 1'b0, "R10");
    access(2'b10, 20'h0F0F0, 8'hA5, 1'b1, 1'b1, 0, 1'b0, "R6");
    access(2'b01, 20'hABCDE, 8'h00, 1'b0, 1'b1, 0, 1'b0, "R3");
    access(2'b10, 20'h54321, 8'h3C, 1'b0, 1'b1, 0, 1'b0, "R3");
    access(2'b00, 20'h01234, 8'h00, 1'b0, 1'b0, 0, 1'b0, "R5");
    access(2'b01, 20'hFEDCB, 8'h00, 1'b1, 1'b1, 3, 1'b0, "R7");
    access(2'b10, 20'h2468A, 8'h5A, 1'b0, 1'b1, 2, 1'b0, "R7");
    access(2'b00, 20'h9ABCD, 8'h00, 1'b1, 1'b0, 3, 1'b0, "R8");
    access(2'b11, 20'h77E01, 8'h00, 1'b1, 1'b1, 0, 1'b0, "R4");
    access(2'b01, 20'h00042, 8'h00, 1'b1, 1'b1, 1, 1'b0, "R10");
    access(2'b01, 20'hC3A01, 8'h00, 1'b0, 1'b1, 0, 1'b1, "R11");
    access(2'b00, 20'h00200, 8'h00, 1'b1, 1'b1, 0, 1'b1, "R11");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R5", "pending expected items", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule